// File: doc/BRIEF.md
# Playback Ramp and Status Pin Generator

This block sits between a voice playback engine and the DAC driver. It takes the engine's 8-bit sample stream and adds anti-pop shaping around it. When shaping is on, a rising ramp runs from zero to mid-scale before the first sample. A falling ramp runs from mid-scale down to zero after the last sample. The same block drives two status pins. An option code routes a stop pulse, a busy level or a pair of flashing LED signals onto those pins.

Every delay, width and period is counted in sample ticks rather than clock cycles, so the timing scales with the sample rate. The ramp lengths are powers of two and are set by the parameters `RISE_LOG2` and `FALL_LOG2`.

The main state machine has four states:
- IDLE: output held at zero.
- RISE: the rising ramp.
- PLAY: samples pass through.
- FALL: the falling ramp.

Its transitions are:
- start: IDLE to RISE, or IDLE to PLAY when shaping is off.
- rise done: RISE to PLAY.
- end: PLAY to FALL, or PLAY to IDLE when shaping is off.
- abort: RISE or PLAY to FALL, or to IDLE when shaping is off.
- fall done: FALL to IDLE.

A second machine produces the stop pulse. Its states are WAIT and HIGH. It is armed by a normal end, WAIT changes to HIGH after the delay, and HIGH returns to its idle state after the width.

Top module: `playback_ramp_status`

## Requirements
- R1: After reset and whenever the block is idle, `dac_code` is 0 and both pins are low.
- R2: With `ramp_en`=1, an accepted start enters RISE. At the k-th tick of RISE, `dac_code` becomes k·128/2^RISE_LOG2. At tick 2^RISE_LOG2 the value reaches 128 and the block enters PLAY.
- R3: In PLAY, each tick loads `sample_in` into `dac_code`. With no tick, `dac_code` holds its value.
- R4: With `ramp_en`=1, `play_end` in PLAY sets `dac_code` to 128 and enters FALL. At the k-th tick of FALL the output is floor(base·(2^FALL_LOG2−k)/2^FALL_LOG2), which reaches 0 at the last tick; the block then returns to IDLE.
- R5: With `ramp_en`=0, a start goes directly to PLAY with no rising ramp. `play_end` returns the block to IDLE at once with `dac_code`=0.
- R6: `play_abort` in RISE or PLAY starts FALL with base equal to the current `dac_code`, or returns to IDLE at once when `ramp_en`=0. An abort never produces a stop pulse.
- R7: Busy is high from the cycle after an accepted start until the block is back in IDLE.
- R8: `play_end` in PLAY with `stop_en`=1 arms the stop pulse. The pulse is high after STOP_DELAY ticks and stays high for STOP_WIDTH ticks. With `stop_en`=0 there is no pulse.
- R9: LED1 goes high at start and toggles every LED_HALF ticks while busy. LED2 is the complement of LED1 while busy. Both LEDs are low when idle.
- R10: `pin_opt` selects the pin roles: 0 drives both pins low; 1 gives pin_a=LED2 and pin_b=LED1; 2 gives pin_a=STOP and pin_b=LED1; 3 gives pin_a=LED1 and pin_b=BUSY.
- R11: `play_start` outside IDLE is ignored. `sample_in` is ignored outside PLAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sample_tick | input | 1 | One-cycle pulse per sample period |
| play_start | input | 1 | Playback start event |
| play_end | input | 1 | Last sample has been delivered |
| play_abort | input | 1 | Stop playback now |
| sample_in | input | 8 | Sample from the playback engine |
| ramp_en | input | 1 | Enable the rising and falling ramps |
| pin_opt | input | 2 | Status pin role code |
| stop_en | input | 1 | Stop pulse enable for the current group |
| dac_code | output | 8 | Code sent to the DAC |
| pin_a | output | 1 | Status pin 1 |
| pin_b | output | 1 | Status pin 2 |

## Verification
The assertions assume the following about the inputs:
- Events are single-cycle pulses.
- `play_end` and `play_abort` never coincide with a tick or with each other.
- `ramp_en` stays constant during a playback.

The bench meets these by driving each event in a cycle of its own with the tick low, and by changing the configuration only while idle. The sweep covers both ramp settings, all four option codes and both stop settings. It also injects aborts during RISE and PLAY, and start events during PLAY and FALL.

// File: rtl/pbr_pkg.sv
package pbr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RISE = 2'd1,
        PH_PLAY = 2'd2,
        PH_FALL = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        SP_IDLE = 2'd0,
        SP_WAIT = 2'd1,
        SP_HIGH = 2'd2
    } stop_st_t;

    typedef enum logic [1:0] {
        PIN_OFF  = 2'd0,
        PIN_LEDS = 2'd1,
        PIN_STOP = 2'd2,
        PIN_BUSY = 2'd3
    } pin_opt_t;

endpackage

// File: rtl/pbr_ramp_fsm.sv
module pbr_ramp_fsm
    import pbr_pkg::*;
#(
    parameter int W         = 8,
    parameter int RISE_LOG2 = 7,
    parameter int FALL_LOG2 = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         play_start,
    input  logic         play_end,
    input  logic         play_abort,
    input  logic         ramp_en,
    input  logic [W-1:0] sample_in,
    output logic [W-1:0] dac_code,
    output phase_t       phase,
    output logic         busy,
    output logic         start_acc,
    output logic         done_evt
);
    localparam int CW = ((RISE_LOG2 > FALL_LOG2) ? RISE_LOG2 : FALL_LOG2) + 1;
    localparam int PW = W + CW;
    localparam int RISE_SH = W - 1 - RISE_LOG2;
    localparam logic [CW-1:0] RISE_CNT = CW'(1 << RISE_LOG2);
    localparam logic [CW-1:0] FALL_CNT = CW'(1 << FALL_LOG2);
    localparam logic [W-1:0]  MID      = W'(1 << (W - 1));

    phase_t        ph_q, ph_d;
    logic [CW-1:0] cnt_q, cnt_inc, fall_left;
    logic [W-1:0]  dac_q, base_q, rise_lvl, fall_lvl;
    logic [PW-1:0] rise_wide, fall_prod;
    logic          leave;

    // Shared step counter; ramp levels come from shifts and one multiply.
    assign cnt_inc   = cnt_q + 1'b1;
    assign fall_left = FALL_CNT - cnt_inc;
    assign rise_wide = PW'(cnt_inc) << RISE_SH;
    assign rise_lvl  = rise_wide[W-1:0];
    assign fall_prod = PW'(base_q) * PW'(fall_left);
    assign fall_lvl  = W'(fall_prod >> FALL_LOG2);
    assign leave     = play_abort || play_end;

    // Next-state logic.
    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE: if (play_start) ph_d = ramp_en ? PH_RISE : PH_PLAY;
            PH_RISE: begin
                if (play_abort)                        ph_d = ramp_en ? PH_FALL : PH_IDLE;
                else if (tick && cnt_inc == RISE_CNT)  ph_d = PH_PLAY;
            end
            PH_PLAY: if (leave) ph_d = ramp_en ? PH_FALL : PH_IDLE;
            PH_FALL: if (tick && cnt_inc == FALL_CNT) ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ph_q <= PH_IDLE;
        else        ph_q <= ph_d;
    end

    // Output datapath.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            dac_q  <= '0;
            base_q <= '0;
        end else begin
            unique case (ph_q)
                PH_IDLE: begin
                    cnt_q <= '0;
                    dac_q <= '0;
                end
                PH_RISE: begin
                    if (play_abort) begin
                        cnt_q  <= '0;
                        base_q <= dac_q;
                        if (!ramp_en) dac_q <= '0;
                    end else if (tick) begin
                        cnt_q <= cnt_inc;
                        dac_q <= rise_lvl;
                    end
                end
                PH_PLAY: begin
                    if (leave) begin
                        cnt_q <= '0;
                        if (!ramp_en) begin
                            dac_q <= '0;
                        end else if (play_abort) begin
                            base_q <= dac_q;
                        end else begin
                            base_q <= MID;
                            dac_q  <= MID;
                        end
                    end else if (tick) begin
                        dac_q <= sample_in;
                    end
                end
                PH_FALL: begin
                    if (tick) begin
                        cnt_q <= cnt_inc;
                        dac_q <= fall_lvl;
                    end
                end
                default: begin
                    cnt_q <= '0;
                    dac_q <= '0;
                end
            endcase
        end
    end

    assign dac_code  = dac_q;
    assign phase     = ph_q;
    assign busy      = (ph_q != PH_IDLE);
    assign start_acc = (ph_q == PH_IDLE) && play_start;
    assign done_evt  = (ph_q == PH_PLAY) && play_end && !play_abort;

endmodule

// File: rtl/pbr_stop_pulse.sv
module pbr_stop_pulse
    import pbr_pkg::*;
#(
    parameter int DELAY = 2,
    parameter int WIDTH = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic trig,
    output logic stop
);
    localparam int MAXC = (DELAY > WIDTH) ? DELAY : WIDTH;
    localparam int SCW  = $clog2(MAXC + 1);
    localparam logic [SCW-1:0] D_LAST = SCW'(DELAY - 1);
    localparam logic [SCW-1:0] W_LAST = SCW'(WIDTH - 1);

    stop_st_t       st_q, st_d;
    logic [SCW-1:0] cnt_q;

    always_comb begin
        st_d = st_q;
        if (trig) begin
            st_d = SP_WAIT;
        end else begin
            unique case (st_q)
                SP_IDLE: st_d = SP_IDLE;
                SP_WAIT: if (tick && cnt_q == D_LAST) st_d = SP_HIGH;
                SP_HIGH: if (tick && cnt_q == W_LAST) st_d = SP_IDLE;
                default: st_d = SP_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SP_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (trig) begin
            cnt_q <= '0;
        end else if (tick && st_q != SP_IDLE) begin
            if (st_d != st_q) cnt_q <= '0;
            else              cnt_q <= cnt_q + 1'b1;
        end
    end

    assign stop = (st_q == SP_HIGH);

endmodule

// File: rtl/pbr_led_flash.sv
module pbr_led_flash #(
    parameter int HALF = 1333
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic start,
    input  logic busy,
    output logic led_main,
    output logic led_alt
);
    localparam int LCW = $clog2(HALF + 1);
    localparam logic [LCW-1:0] H_LAST = LCW'(HALF - 1);

    logic           ph_q;
    logic [LCW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            ph_q  <= 1'b1;
            cnt_q <= '0;
        end else if (!busy) begin
            ph_q  <= 1'b0;
            cnt_q <= '0;
        end else if (tick) begin
            if (cnt_q == H_LAST) begin
                cnt_q <= '0;
                ph_q  <= ~ph_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign led_main = ph_q & busy;
    assign led_alt  = ~ph_q & busy;

endmodule

// File: rtl/pbr_pin_map.sv
module pbr_pin_map
    import pbr_pkg::*;
(
    input  logic [1:0] opt,
    input  logic       led_main,
    input  logic       led_alt,
    input  logic       stop,
    input  logic       busy,
    output logic       pin_a,
    output logic       pin_b
);
    always_comb begin
        unique case (pin_opt_t'(opt))
            PIN_OFF:  begin pin_a = 1'b0;     pin_b = 1'b0;     end
            PIN_LEDS: begin pin_a = led_alt;  pin_b = led_main; end
            PIN_STOP: begin pin_a = stop;     pin_b = led_main; end
            PIN_BUSY: begin pin_a = led_main; pin_b = busy;     end
            default:  begin pin_a = 1'b0;     pin_b = 1'b0;     end
        endcase
    end

endmodule

// File: rtl/playback_ramp_status.sv
module playback_ramp_status
    import pbr_pkg::*;
#(
    parameter int SAMPLE_W   = 8,
    parameter int RISE_LOG2  = 7,
    parameter int FALL_LOG2  = 8,
    parameter int STOP_DELAY = 2,
    parameter int STOP_WIDTH = 512,
    parameter int LED_HALF   = 1333
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sample_tick,
    input  logic                play_start,
    input  logic                play_end,
    input  logic                play_abort,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic                ramp_en,
    input  logic [1:0]          pin_opt,
    input  logic                stop_en,
    output logic [SAMPLE_W-1:0] dac_code,
    output logic                pin_a,
    output logic                pin_b
);
    phase_t phase_w;
    logic   busy_w, start_w, done_w, stop_w, led_main_w, led_alt_w;

    pbr_ramp_fsm #(.W(SAMPLE_W), .RISE_LOG2(RISE_LOG2), .FALL_LOG2(FALL_LOG2)) u_ramp (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick),
        .play_start(play_start), .play_end(play_end), .play_abort(play_abort),
        .ramp_en(ramp_en), .sample_in(sample_in), .dac_code(dac_code),
        .phase(phase_w), .busy(busy_w), .start_acc(start_w), .done_evt(done_w)
    );

    pbr_stop_pulse #(.DELAY(STOP_DELAY), .WIDTH(STOP_WIDTH)) u_stop (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick),
        .trig(done_w && stop_en), .stop(stop_w)
    );

    pbr_led_flash #(.HALF(LED_HALF)) u_led (
        .clk(clk), .rst_n(rst_n), .tick(sample_tick), .start(start_w),
        .busy(busy_w), .led_main(led_main_w), .led_alt(led_alt_w)
    );

    pbr_pin_map u_pins (
        .opt(pin_opt), .led_main(led_main_w), .led_alt(led_alt_w),
        .stop(stop_w), .busy(busy_w), .pin_a(pin_a), .pin_b(pin_b)
    );

endmodule

// File: rtl/pbr_checker.sv
module pbr_checker
    import pbr_pkg::*;
#(
    parameter int STOP_WIDTH = 512
) (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       play_start,
    input logic       play_end,
    input logic       play_abort,
    input logic       ramp_en,
    input logic [7:0] dac,
    input logic       busy,
    input phase_t     phase,
    input logic       stop
);
    logic [31:0] stop_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stop_ticks <= '0;
        else if (!stop) stop_ticks <= '0;
        else if (tick)  stop_ticks <= stop_ticks + 1;
    end

    assert_idle_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> dac == 8'd0);

    assert_rise_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RISE && tick && !play_abort) |=> dac > $past(dac));

    assert_hold_no_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !play_start && !play_end && !play_abort) |=> $stable(dac));

    assert_fall_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FALL) |=> dac <= $past(dac));

    assert_direct_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ramp_en && phase == PH_PLAY && play_end) |=> !busy);

    assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && play_start) |=> busy);

    assert_stop_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ticks <= STOP_WIDTH);

endmodule

bind playback_ramp_status pbr_checker #(.STOP_WIDTH(STOP_WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(sample_tick), .play_start(play_start),
    .play_end(play_end), .play_abort(play_abort), .ramp_en(ramp_en),
    .dac(dac_code), .busy(busy_w), .phase(phase_w), .stop(stop_w)
);

// File: tb/tb_playback_ramp_status.sv
module tb_playback_ramp_status;
    localparam int CLK_PERIOD = 10;
    localparam int RL = 3;
    localparam int FL = 4;
    localparam int SD = 2;
    localparam int SW = 6;
    localparam int LH = 5;
    localparam int UPN = 1 << RL;
    localparam int DNN = 1 << FL;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, start = 1'b0, pend = 1'b0, abt = 1'b0;
    logic       ramp_en = 1'b0, stop_en = 1'b0;
    logic [7:0] smp = 8'd0;
    logic [1:0] opt = 2'd0;
    logic [7:0] dac;
    logic       pa, pb;

    int n_chk = 0, n_err = 0;
    int busy_m = 0, led_n = 0, stop_t = -1, dac_m = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    playback_ramp_status #(
        .SAMPLE_W(8), .RISE_LOG2(RL), .FALL_LOG2(FL),
        .STOP_DELAY(SD), .STOP_WIDTH(SW), .LED_HALF(LH)
    ) dut (
        .clk(clk), .rst_n(rst_n), .sample_tick(tick), .play_start(start),
        .play_end(pend), .play_abort(abt), .sample_in(smp), .ramp_en(ramp_en),
        .pin_opt(opt), .stop_en(stop_en), .dac_code(dac), .pin_a(pa), .pin_b(pb)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    // Drive one cycle of inputs from a falling edge; return at the next falling edge.
    task automatic cyc(input bit tk, input bit st, input bit en, input bit ab);
        tick = tk; start = st; pend = en; abt = ab;
        @(negedge clk);
        tick = 1'b0; start = 1'b0; pend = 1'b0; abt = 1'b0;
        if (tk) begin
            if (busy_m != 0) led_n++;
            if (stop_t >= 0) stop_t++;
        end
    endtask

    task automatic check_all(input string req);
        int l1, l2, st, ea, eb;
        l1 = (busy_m != 0 && ((led_n / LH) % 2) == 0) ? 1 : 0;
        l2 = (busy_m != 0 && ((led_n / LH) % 2) == 1) ? 1 : 0;
        st = (stop_t >= SD && stop_t < SD + SW) ? 1 : 0;
        case (opt)
            2'd0:    begin ea = 0;  eb = 0;      end
            2'd1:    begin ea = l2; eb = l1;     end
            2'd2:    begin ea = st; eb = l1;     end
            default: begin ea = l1; eb = busy_m; end
        endcase
        chk({req, " dac_code"}, int'(dac), dac_m);
        chk({"R9/R10 pin_a in ", req}, int'(pa), ea);
        chk({"R9/R10 pin_b in ", req}, int'(pb), eb);
    endtask

    task automatic run_play(input bit r, input int o, input bit s, input int nsamp);
        int v;
        ramp_en = r; opt = 2'(o); stop_en = s;
        cyc(0, 1, 0, 0);
        busy_m = 1; led_n = 0; dac_m = 0;
        check_all("R7 start");
        if (r) begin
            for (int k = 1; k <= UPN; k++) begin
                smp = 8'(255 - k);
                cyc(1, 0, 0, 0);
                dac_m = k * (128 / UPN);
                check_all("R2 rise, R11 sample ignored");
            end
        end
        for (int i = 0; i < nsamp; i++) begin
            v = (i * 37 + o * 53 + int'(r) * 101 + 7) % 256;
            smp = 8'(v);
            cyc(1, 0, 0, 0);
            dac_m = v;
            check_all("R3 sample load");
            smp = ~smp;
            cyc(0, 0, 0, 0);
            check_all("R3 hold without tick");
            if (i == 2) begin
                cyc(0, 1, 0, 0);
                check_all("R11 start in PLAY ignored");
            end
        end
        cyc(0, 0, 1, 0);
        if (s) stop_t = 0;
        if (r) begin
            dac_m = 128;
        end else begin
            dac_m = 0;
            busy_m = 0;
        end
        check_all(r ? "R4 end to midpoint" : "R5 direct end");
        if (r) begin
            for (int k = 1; k <= DNN; k++) begin
                cyc(1, 0, 0, 0);
                dac_m = (128 * (DNN - k)) / DNN;
                if (k == DNN) busy_m = 0;
                check_all("R4 fall");
            end
        end
        for (int j = 0; j < SD + SW + 2; j++) begin
            cyc(1, 0, 0, 0);
            check_all(s ? "R8 stop pulse" : "R8 no stop pulse");
        end
        stop_t = -1;
    endtask

    task automatic run_abort(input bit r, input bit in_play);
        int base;
        ramp_en = r; opt = 2'd2; stop_en = 1'b1;
        cyc(0, 1, 0, 0);
        busy_m = 1; led_n = 0; dac_m = 0;
        check_all("R7 start");
        if (r) begin
            for (int k = 1; k <= (in_play ? UPN : 3); k++) begin
                cyc(1, 0, 0, 0);
                dac_m = k * (128 / UPN);
                check_all("R2 rise");
            end
        end
        if (in_play) begin
            smp = 8'd200;
            cyc(1, 0, 0, 0);
            dac_m = 200;
            check_all("R3 sample load");
        end
        cyc(0, 0, 0, 1);
        if (!r) begin
            dac_m = 0;
            busy_m = 0;
        end
        check_all("R6 abort");
        base = dac_m;
        if (r) begin
            for (int k = 1; k <= DNN; k++) begin
                if (k == 5) begin
                    cyc(0, 1, 0, 0);
                    check_all("R11 start in FALL ignored");
                end
                cyc(1, 0, 0, 0);
                dac_m = (base * (DNN - k)) / DNN;
                if (k == DNN) busy_m = 0;
                check_all("R6 fall from current value");
            end
        end
        for (int j = 0; j < SD + SW + 2; j++) begin
            cyc(1, 0, 0, 0);
            check_all("R6 no stop after abort");
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        opt = 2'd3;
        check_all("R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 idle after reset");
        opt = 2'd1;
        check_all("R1 idle LEDs");
        for (int r = 0; r < 2; r++)
            for (int o = 0; o < 4; o++)
                for (int s = 0; s < 2; s++)
                    run_play(r[0], o, s[0], 12);
        run_abort(1'b1, 1'b0);
        run_abort(1'b1, 1'b1);
        run_abort(1'b0, 1'b1);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule